// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block keeps the configuration and the two position pointers of one circular descriptor queue that software and a DMA engine share. Software programs the base address and the queue length through a small write port. Each field is protected by its own enable bit. One side produces entries by moving the write position forward, and the other side consumes them by moving the read position. The block tracks both positions, wraps them at the programmed length, and reports how many slots are filled and how many are free. It also gives the DMA engine a ready level, an acknowledge, and the byte address of the descriptor it should touch next.

A parameter selects which of the four queue roles an instance plays:

- **Receive free:** software fills, hardware consumes.
- **Receive busy:** hardware fills, software consumes.
- **Transmit busy:** software fills, hardware consumes.
- **Transmit reclaim:** hardware fills, software consumes.

The role decides which pointer the hardware owns and which bit of the shared four-bit engine-enable input gates it. A chip instantiates one copy per queue. Descriptors are 32 bytes long. Pointers are seen in byte units, and the length is programmed in 8-byte word units.

Top module: `desc_ring_ctrl`

## Requirements
- R1: After reset the base address is 0, the length readback is MAX_DESC shifted left by 3, both pointers are 0, the queue is empty, the free count equals MAX_DESC, and the underflow flag is clear.
- R2: The gate register (select 4) stores the depth-enable bit from data bit 1 and the start-enable bit from data bit 2. It reads back in the same positions, with bit 0 always 0. A length write (select 1) takes data shifted right by 3 as the descriptor count. It is accepted only while the depth-enable bit is set and the count lies in 2..MAX_DESC. The length reads back as the count shifted left by 3.
- R3: A base address write (select 0) is accepted only while the start-enable bit is set. Any accepted base or length write returns both pointers to 0 and clears the underflow flag.
- R4: Pointers read back as slot index shifted left by 5. Software may write only the pointer it owns: write pointer at select 2 for hardware-consuming roles, read pointer at select 3 for hardware-filling roles. The written slot is data shifted right by 5, and it must be below the length. Writes to the other pointer and out-of-range slots have no effect.
- R5: One slot always stays empty. A software write-pointer move of `step = (new - old) mod length` is accepted only when `step` is less than the free count. A software read-pointer move is accepted only when `step` is at most the used count.
- R6: The used count is `(wr - rd) mod length`, and the free count is `length - used`. The empty flag is set when used is 0, and the full flag is set when free is 1.
- R7: Each accepted hardware advance moves the hardware-owned pointer by one slot. The pointer wraps to 0 when it reaches the length.
- R8: Role-to-enable mapping: receive free uses bit 2, receive busy bit 3, transmit busy bit 0, transmit reclaim bit 1. While the role's bit is clear, a hardware advance has no effect and is not acknowledged.
- R9: In a hardware-consuming role, an enabled advance on an empty queue moves nothing and sets a sticky underflow flag. In a hardware-filling role, an enabled advance on a full queue moves nothing.
- R10: The descriptor address equals the base address plus the hardware-owned pointer in bytes.
- R11: The ready output is high when the role's enable bit is set and the queue is not empty (hardware consumer) or not full (hardware filler). The acknowledge output is the advance request gated by ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 base, 1 length, 2 write pointer, 3 read pointer, 4 gate |
| reg_wdata | input | AW | Register write data |
| desc_en | input | 4 | Shared engine-enable bits |
| hw_adv | input | 1 | Hardware advance request |
| start_addr | output | AW | Base address |
| depth_reg | output | AW | Length readback (count shifted left by 3) |
| wr_ptr | output | AW | Write pointer in bytes |
| rd_ptr | output | AW | Read pointer in bytes |
| cfg_gate | output | 3 | Gate register readback |
| used_cnt | output | CW | Filled slots |
| free_cnt | output | CW | Length minus filled slots |
| ring_empty | output | 1 | Queue empty |
| ring_full | output | 1 | Only the reserved slot remains |
| underflow | output | 1 | Sticky empty-consume flag |
| hw_ready | output | 1 | Hardware side may advance |
| hw_ack | output | 1 | Advance accepted this cycle |
| desc_addr | output | AW | Address of the next hardware descriptor |

## Verification
The bench drives a hardware-consuming and a hardware-filling instance with the same stimulus. It targets the boundary slots:

- **Filling the last slot:** a design without the reserved slot would report an empty queue after a full lap.
- **Consuming past the producer:** a missing check would let the read pointer overtake the write pointer.
- **Wrap at a non-power-of-two length:** a design that wraps at MAX_DESC instead of the programmed length would walk out of range.
- **Enable mapping:** a wrong bit would let the wrong role move.

It also covers two configuration cases. Writes made with the gate clear must leave the configuration untouched. Accepted configuration changes must zero both pointers, or stale positions would survive a reprogram. Random traffic over short lengths then hits these cases repeatedly against a bench model.

// File: rtl/ring_pkg.sv
package ring_pkg;

    typedef enum logic [1:0] {
        RK_RX_FREE,
        RK_RX_BUSY,
        RK_TX_BUSY,
        RK_TX_RECLAIM
    } ring_kind_e;

    typedef enum logic [2:0] {
        SEL_START = 3'd0,
        SEL_DEPTH = 3'd1,
        SEL_WPTR  = 3'd2,
        SEL_RPTR  = 3'd3,
        SEL_GATE  = 3'd4
    } reg_sel_e;

    localparam int GATE_DEPTH_BIT = 1;
    localparam int GATE_START_BIT = 2;

    typedef struct packed {
        logic ready;
        logic ack;
        logic uf_evt;
    } hw_side_t;

    // Roles in which the engine produces entries (owns the write pointer)
    function automatic logic hw_fills(ring_kind_e k);
        return (k == RK_RX_BUSY) || (k == RK_TX_RECLAIM);
    endfunction

    // Bit of the shared engine-enable word that gates each role
    function automatic int enable_bit(ring_kind_e k);
        case (k)
            RK_RX_FREE:    return 2;
            RK_RX_BUSY:    return 3;
            RK_TX_BUSY:    return 0;
            default:       return 1;
        endcase
    endfunction

endpackage

// File: rtl/ring_cfg.sv
module ring_cfg
    import ring_pkg::*;
#(
    parameter int AW       = 32,
    parameter int MAX_DESC = 64,
    parameter int CW       = 7,
    parameter int WSH      = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  reg_sel_e      sel,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] start_q,
    output logic [CW-1:0] depth_q,
    output logic [1:0]    gate_q,    // [0] depth enable, [1] start enable
    output logic          cfg_load
);

    logic [AW-1:0] depth_cand;
    logic          depth_ok;
    logic          start_acc;
    logic          depth_acc;

    assign depth_cand = wdata >> WSH;
    assign depth_ok   = (depth_cand >= AW'(2)) && (depth_cand <= AW'(MAX_DESC));
    assign start_acc  = reg_we && (sel == SEL_START) && gate_q[1];
    assign depth_acc  = reg_we && (sel == SEL_DEPTH) && gate_q[0] && depth_ok;
    assign cfg_load   = start_acc || depth_acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            depth_q <= CW'(MAX_DESC);
            gate_q  <= '0;
        end else begin
            if (reg_we && (sel == SEL_GATE)) begin
                gate_q <= {wdata[GATE_START_BIT], wdata[GATE_DEPTH_BIT]};
            end
            if (start_acc) begin
                start_q <= wdata;
            end
            if (depth_acc) begin
                depth_q <= depth_cand[CW-1:0];
            end
        end
    end

    AST_DEPTH_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (depth_q >= CW'(2)) && (depth_q <= CW'(MAX_DESC))); // R2

    AST_DEPTH_GATED: assert property (@(posedge clk) disable iff (rst)
        !gate_q[0] |=> $stable(depth_q)); // R2

    AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
        !gate_q[1] |=> $stable(start_q)); // R3

endmodule

// File: rtl/ring_ptr.sv
module ring_ptr
    import ring_pkg::*;
#(
    parameter ring_kind_e KIND = RK_RX_FREE,
    parameter int AW  = 32,
    parameter int IW  = 6,
    parameter int CW  = 7,
    parameter int BSH = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] depth_q,
    input  logic          cfg_load,
    input  logic          reg_we,
    input  reg_sel_e      sel,
    input  logic [AW-1:0] wdata,
    input  logic          hw_en,
    input  logic          hw_adv,
    output logic [IW-1:0] wr_idx,
    output logic [IW-1:0] rd_idx,
    output logic [IW-1:0] hw_idx,
    output logic [CW-1:0] used,
    output logic [CW-1:0] free,
    output logic          empty,
    output logic          full,
    output logic          underflow,
    output hw_side_t      hw
);

    localparam logic     HW_FILLS = hw_fills(KIND);
    localparam reg_sel_e SW_SEL   = HW_FILLS ? SEL_RPTR : SEL_WPTR;

    logic [IW-1:0] sw_idx;
    logic [CW-1:0] wr_c, rd_c, sw_c, hw_c, hw_inc;
    logic [AW-1:0] cand_slot;
    logic [CW-1:0] cand_c;
    logic          cand_in_range;
    logic [CW-1:0] sw_step;
    logic          sw_room;
    logic          sw_accept;

    function automatic logic [CW-1:0] fwd_dist(logic [CW-1:0] to_pos,
                                                logic [CW-1:0] from_pos,
                                                logic [CW-1:0] len);
        return (to_pos >= from_pos) ? (to_pos - from_pos)
                                    : (len - from_pos + to_pos);
    endfunction

    // Ownership mapping picked by the role
    generate
        if (HW_FILLS) begin : g_hw_fills
            assign wr_idx = hw_idx;
            assign rd_idx = sw_idx;
        end else begin : g_hw_drains
            assign wr_idx = sw_idx;
            assign rd_idx = hw_idx;
        end
    endgenerate

    assign wr_c  = CW'(wr_idx);
    assign rd_c  = CW'(rd_idx);
    assign sw_c  = CW'(sw_idx);
    assign hw_c  = CW'(hw_idx);
    assign used  = fwd_dist(wr_c, rd_c, depth_q);
    assign free  = depth_q - used;
    assign empty = (used == '0);
    assign full  = (free == CW'(1));

    assign hw_inc = ((hw_c + CW'(1)) == depth_q) ? '0 : (hw_c + CW'(1));

    assign hw.ready  = hw_en && (HW_FILLS ? !full : !empty);
    assign hw.ack    = hw_adv && hw.ready;
    assign hw.uf_evt = !HW_FILLS && hw_adv && hw_en && empty;

    // Software move of its own pointer
    assign cand_slot     = wdata >> BSH;
    assign cand_in_range = cand_slot < AW'(depth_q);
    assign cand_c        = cand_slot[CW-1:0];
    assign sw_step       = fwd_dist(cand_c, sw_c, depth_q);
    assign sw_room       = HW_FILLS ? (sw_step <= used) : (sw_step < free);
    assign sw_accept     = reg_we && (sel == SW_SEL) && cand_in_range && sw_room;

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_idx    <= '0;
            hw_idx    <= '0;
            underflow <= 1'b0;
        end else if (cfg_load) begin
            sw_idx    <= '0;
            hw_idx    <= '0;
            underflow <= 1'b0;
        end else begin
            if (sw_accept) begin
                sw_idx <= cand_c[IW-1:0];
            end
            if (hw.ack) begin
                hw_idx <= hw_inc[IW-1:0];
            end
            if (hw.uf_evt) begin
                underflow <= 1'b1;
            end
        end
    end

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (CW'(wr_idx) < depth_q) && (CW'(rd_idx) < depth_q)); // R7

    AST_HW_STEP: assert property (@(posedge clk) disable iff (rst)
        (hw.ack && !cfg_load) |=>
            ((CW'($past(hw_idx)) + CW'(1) == depth_q) ? (hw_idx == '0)
                : (CW'(hw_idx) == CW'($past(hw_idx)) + CW'(1)))); // R7

    AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> (wr_idx == '0) && (rd_idx == '0) && !underflow); // R3

    AST_UF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (underflow && !cfg_load) |=> underflow); // R9

    AST_FREE_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (free >= CW'(1)) && (used < depth_q)); // R6

    AST_HW_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!hw_en && !cfg_load) |=> $stable(hw_idx)); // R8

endmodule

// File: rtl/ring_addr.sv
module ring_addr #(
    parameter int AW  = 32,
    parameter int IW  = 6,
    parameter int BSH = 5
) (
    input  logic [AW-1:0] start_q,
    input  logic [IW-1:0] wr_idx,
    input  logic [IW-1:0] rd_idx,
    input  logic [IW-1:0] hw_idx,
    output logic [AW-1:0] wr_bytes,
    output logic [AW-1:0] rd_bytes,
    output logic [AW-1:0] desc_addr
);

    assign wr_bytes  = AW'(wr_idx) << BSH;
    assign rd_bytes  = AW'(rd_idx) << BSH;
    assign desc_addr = start_q + (AW'(hw_idx) << BSH);

endmodule

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl
    import ring_pkg::*;
#(
    parameter ring_kind_e KIND  = RK_RX_FREE,
    parameter int AW            = 32,
    parameter int MAX_DESC      = 64,
    parameter int DESC_BYTES    = 32,
    parameter int WORD_BYTES    = 8,
    localparam int CW           = $clog2(MAX_DESC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [2:0]    reg_sel,
    input  logic [AW-1:0] reg_wdata,
    input  logic [3:0]    desc_en,
    input  logic          hw_adv,
    output logic [AW-1:0] start_addr,
    output logic [AW-1:0] depth_reg,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [2:0]    cfg_gate,
    output logic [CW-1:0] used_cnt,
    output logic [CW-1:0] free_cnt,
    output logic          ring_empty,
    output logic          ring_full,
    output logic          underflow,
    output logic          hw_ready,
    output logic          hw_ack,
    output logic [AW-1:0] desc_addr
);

    localparam int IW     = $clog2(MAX_DESC);
    localparam int BSH    = $clog2(DESC_BYTES);
    localparam int WSH    = $clog2(WORD_BYTES);
    localparam int EN_BIT = enable_bit(KIND);

    reg_sel_e      sel;
    logic [CW-1:0] depth_q;
    logic [1:0]    gate_q;
    logic          cfg_load;
    logic [IW-1:0] wr_idx, rd_idx, hw_idx;
    hw_side_t      hw;

    assign sel = reg_sel_e'(reg_sel);

    ring_cfg #(.AW(AW), .MAX_DESC(MAX_DESC), .CW(CW), .WSH(WSH)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .reg_we   (reg_we),
        .sel      (sel),
        .wdata    (reg_wdata),
        .start_q  (start_addr),
        .depth_q  (depth_q),
        .gate_q   (gate_q),
        .cfg_load (cfg_load)
    );

    ring_ptr #(.KIND(KIND), .AW(AW), .IW(IW), .CW(CW), .BSH(BSH)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .depth_q   (depth_q),
        .cfg_load  (cfg_load),
        .reg_we    (reg_we),
        .sel       (sel),
        .wdata     (reg_wdata),
        .hw_en     (desc_en[EN_BIT]),
        .hw_adv    (hw_adv),
        .wr_idx    (wr_idx),
        .rd_idx    (rd_idx),
        .hw_idx    (hw_idx),
        .used      (used_cnt),
        .free      (free_cnt),
        .empty     (ring_empty),
        .full      (ring_full),
        .underflow (underflow),
        .hw        (hw)
    );

    ring_addr #(.AW(AW), .IW(IW), .BSH(BSH)) u_addr (
        .start_q   (start_addr),
        .wr_idx    (wr_idx),
        .rd_idx    (rd_idx),
        .hw_idx    (hw_idx),
        .wr_bytes  (wr_ptr),
        .rd_bytes  (rd_ptr),
        .desc_addr (desc_addr)
    );

    assign depth_reg = AW'(depth_q) << WSH;
    assign cfg_gate  = {gate_q[1], gate_q[0], 1'b0};
    assign hw_ready  = hw.ready;
    assign hw_ack    = hw.ack;

    AST_ACK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        hw_ack |-> desc_en[EN_BIT]); // R8

    AST_ADDR_TRACKS_START: assert property (@(posedge clk) disable iff (rst)
        (ring_empty && hw_idx == '0) |-> (desc_addr == start_addr)); // R10

endmodule

// File: tb/desc_ring_ctrl_test.sv
module desc_ring_ctrl_test;
    import ring_pkg::*;

    localparam int MAXD = 64;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst;
    logic        reg_we;
    logic [2:0]  reg_sel;
    logic [31:0] reg_wdata;
    logic [3:0]  desc_en;
    logic        hw_adv;

    logic [31:0] st0, dr0, wp0, rp0, da0, st1, dr1, wp1, rp1, da1;
    logic [2:0]  g0, g1;
    logic [6:0]  us0, fr0, us1, fr1;
    logic        em0, fu0, uf0, rdy0, ack0, em1, fu1, uf1, rdy1, ack1;

    desc_ring_ctrl #(.KIND(RK_RX_FREE)) uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .desc_en(desc_en), .hw_adv(hw_adv),
        .start_addr(st0), .depth_reg(dr0), .wr_ptr(wp0), .rd_ptr(rp0),
        .cfg_gate(g0), .used_cnt(us0), .free_cnt(fr0), .ring_empty(em0),
        .ring_full(fu0), .underflow(uf0), .hw_ready(rdy0), .hw_ack(ack0),
        .desc_addr(da0));

    desc_ring_ctrl #(.KIND(RK_RX_BUSY)) uut_b (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .desc_en(desc_en), .hw_adv(hw_adv),
        .start_addr(st1), .depth_reg(dr1), .wr_ptr(wp1), .rd_ptr(rp1),
        .cfg_gate(g1), .used_cnt(us1), .free_cnt(fr1), .ring_empty(em1),
        .ring_full(fu1), .underflow(uf1), .hw_ready(rdy1), .hw_ack(ack1),
        .desc_addr(da1));

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model; index 0 = engine consumes (enable bit 2), 1 = engine fills (bit 3)
    int unsigned m_start [2];
    int          m_depth [2];
    int          m_sw    [2];
    int          m_hw    [2];
    bit          m_uf    [2];
    bit [1:0]    m_gate  [2];

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int m_wr(int k);
        return (k == 1) ? m_hw[k] : m_sw[k];
    endfunction
    function automatic int m_rd(int k);
        return (k == 1) ? m_sw[k] : m_hw[k];
    endfunction
    function automatic int m_used(int k);
        return (m_wr(k) - m_rd(k) + m_depth[k]) % m_depth[k];
    endfunction
    function automatic bit m_ready(int k, logic [3:0] en);
        bit enb = (k == 0) ? en[2] : en[3];
        if (k == 1) return enb && ((m_depth[k] - m_used(k)) != 1);
        return enb && (m_used(k) != 0);
    endfunction

    function automatic void m_reset();
        for (int k = 0; k < 2; k++) begin
            m_start[k] = 0; m_depth[k] = MAXD; m_sw[k] = 0; m_hw[k] = 0;
            m_uf[k] = 0; m_gate[k] = 2'b00;
        end
    endfunction

    function automatic void m_step(bit we, int sel, logic [31:0] wd,
                                   logic [3:0] en, bit adv);
        for (int k = 0; k < 2; k++) begin
            int  used  = m_used(k);
            int  free  = m_depth[k] - used;
            bit  enb   = (k == 0) ? en[2] : en[3];
            int  cand  = int'(wd >> 3);
            bit  s_acc = we && sel == 0 && m_gate[k][1];
            bit  d_acc = we && sel == 1 && m_gate[k][0] && (wd >> 3) >= 2
                         && (wd >> 3) <= MAXD;
            bit  rdy   = m_ready(k, en);
            if (we && sel == 4) m_gate[k] = {wd[2], wd[1]};
            if (s_acc || d_acc) begin
                if (s_acc) m_start[k] = wd;
                if (d_acc) m_depth[k] = cand;
                m_sw[k] = 0; m_hw[k] = 0; m_uf[k] = 0;
            end else begin
                int own_sel = (k == 1) ? 3 : 2;
                if (we && sel == own_sel && (wd >> 5) < m_depth[k]) begin
                    int c = int'(wd >> 5);
                    int step = (c - m_sw[k] + m_depth[k]) % m_depth[k];
                    if ((k == 1) ? (step <= used) : (step < free)) m_sw[k] = c;
                end
                if (adv && rdy) m_hw[k] = (m_hw[k] + 1) % m_depth[k];
                if (k == 0 && adv && enb && used == 0) m_uf[k] = 1;
            end
        end
    endfunction

    task automatic check_inst(int k, logic [31:0] st, logic [31:0] dr,
                              logic [31:0] wp, logic [31:0] rp, logic [2:0] g,
                              logic [6:0] us, logic [6:0] fr, logic em,
                              logic fu, logic uf, logic [31:0] da);
        int u = m_used(k);
        logic [31:0] exp_da = m_start[k] + 32'(m_hw[k] * 32);
        chk("R3 start", st, m_start[k]);
        chk("R2 depth", dr, m_depth[k] * 8);
        chk("R7 wr_ptr", wp, m_wr(k) * 32);
        chk("R7 rd_ptr", rp, m_rd(k) * 32);
        chk("R2 gate", g, {m_gate[k], 1'b0});
        chk("R6 used", us, u);
        chk("R6 free", fr, m_depth[k] - u);
        chk("R6 empty", em, u == 0);
        chk("R6 full", fu, (m_depth[k] - u) == 1);
        chk("R9 underflow", uf, m_uf[k]);
        chk("R10 desc_addr", da, exp_da);
    endtask

    task automatic cyc(bit we, int sel, logic [31:0] wd, logic [3:0] en, bit adv);
        reg_we = we; reg_sel = 3'(sel); reg_wdata = wd; desc_en = en; hw_adv = adv;
        #1;
        chk("R11 ready0", rdy0, m_ready(0, en));
        chk("R11 ack0", ack0, adv && m_ready(0, en));
        chk("R11 ready1", rdy1, m_ready(1, en));
        chk("R11 ack1", ack1, adv && m_ready(1, en));
        @(posedge clk);
        m_step(we, sel, wd, en, adv);
        @(negedge clk);
        check_inst(0, st0, dr0, wp0, rp0, g0, us0, fr0, em0, fu0, uf0, da0);
        check_inst(1, st1, dr1, wp1, rp1, g1, us1, fr1, em1, fu1, uf1, da1);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; reg_we = 0; reg_sel = 0; reg_wdata = 0; desc_en = 0; hw_adv = 0;
        m_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk("R1 start", st0, 0);
        chk("R1 depth", dr0, MAXD * 8);
        chk("R1 ptrs", wp0 | rp0 | wp1 | rp1, 0);
        chk("R1 empty", em0 && em1, 1);
        chk("R1 free", fr0, MAXD);
        chk("R1 underflow", uf0 | uf1, 0);
        @(negedge clk);

        cyc(1, 1, 32'd32, 4'b0000, 0);           // gate clear: length ignored
        chk("R2 gated length", dr0, MAXD * 8);
        cyc(1, 4, 32'h2, 4'b0000, 0);            // depth enable only
        cyc(1, 1, 32'd32, 4'b0000, 0);           // length 4
        chk("R2 length accepted", dr0, 32);
        cyc(1, 1, 32'd8, 4'b0000, 0);            // count 1 illegal
        chk("R2 length too small", dr0, 32);
        cyc(1, 0, 32'h1000, 4'b0000, 0);
        chk("R3 gated start", st0, 0);
        cyc(1, 4, 32'h6, 4'b0000, 0);
        cyc(1, 0, 32'h1000, 4'b0000, 0);
        chk("R3 start accepted", st0, 32'h1000);

        cyc(1, 2, 32'd96, 4'b0000, 0);           // sw fill to slot 3
        chk("R5 fill to reserve", wp0, 96);
        chk("R6 full flag", fu0, 1);
        chk("R4 foreign pointer ignored", wp1, 0);
        cyc(1, 2, 32'd0, 4'b0000, 0);            // would use reserved slot
        chk("R5 reserved slot kept", wp0, 96);
        cyc(1, 2, 32'd160, 4'b0000, 0);          // slot 5 out of range
        chk("R4 out of range", wp0, 96);
        cyc(1, 3, 32'd32, 4'b0000, 0);
        chk("R4 rd write ignored", rp0, 0);

        cyc(0, 0, 0, 4'b0000, 1);
        chk("R8 disabled no move", rp0, 0);
        cyc(0, 0, 0, 4'b0100, 1);
        chk("R8 bit2 moves consumer", rp0, 32);
        chk("R8 bit2 not for filler", wp1, 0);
        chk("R10 addr", da0, 32'h1020);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 4'b1100, 1);
        chk("R9 underflow set", uf0, 1);
        chk("R9 consumer held", rp0, 96);
        chk("R9 filler held at full", wp1, 96);
        cyc(1, 3, 32'd96, 4'b0000, 0);
        chk("R5 sw consume ok", rp1, 96);
        cyc(1, 3, 32'd0, 4'b0000, 0);
        chk("R5 sw consume past producer", rp1, 96);
        cyc(1, 2, 32'd64, 4'b0000, 0);
        cyc(0, 0, 0, 4'b1100, 1);
        chk("R7 consumer wrap", rp0, 0);
        chk("R7 filler wrap", wp1, 0);
        cyc(1, 1, 32'd64, 4'b0000, 0);
        chk("R3 reprogram clears", wp0 | rp0 | uf0, 0);

        for (int i = 0; i < 3000; i++) begin
            int op = int'($urandom % 16);
            logic [3:0] en = ($urandom % 4 == 0) ? 4'($urandom) : 4'b1100;
            bit adv = 1'($urandom);
            case (op)
                0: cyc(1, 1, ($urandom % 12 == 0) ? 32'd560 : (1 + $urandom % 9) << 3, en, adv);
                1: cyc(1, 0, $urandom & 32'hFFFF_FFE0, en, adv);
                2: cyc(1, 4, ($urandom % 3 == 0) ? $urandom % 8 : 32'h6, en, adv);
                3, 4, 5, 6: cyc(1, 2, ($urandom % 10) << 5, en, adv);
                7, 8, 9, 10: cyc(1, 3, ($urandom % 10) << 5, en, adv);
                default: cyc(0, 0, 0, en, adv);
            endcase
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule